// File: doc/BRIEF.md
# Execution Trace Header Encoder

This block turns the per-cycle status strobes of a processing core into trace header records. Every clock cycle it samples four conditions: an instruction is stalled, an instruction retires, a secure wipe is in progress, and a secure wipe has finished. When at least one of them is present, it produces one record on the following cycle. The record holds an ASCII type character, a bitmask of the conditions that were seen, and the cycle number in which they were seen. Instruction records also carry the program counter and the raw instruction word.

A trace collector sits downstream and turns the records into text. The encoder does not decide whether the core is behaving correctly. It only marks a record with an error flag when the inputs contradict each other. That happens when two or more conditions arrive in the same cycle, or when a retiring instruction does not match the program counter of the stall that came before it.

The record output is qualified by a valid strobe and has no ready input. Each record lasts exactly one cycle, so the consumer must accept a record in every cycle in which `rec_valid_o` is high. No back-pressure is possible and nothing is buffered.

Top module: `trc_hdr_enc`

## Requirements
- R1: The type codes are ASCII 'S' = 0x53 (stall), 'E' = 0x45 (retire), 'U' = 0x55 (wipe in progress) and 'V' = 0x56 (wipe complete). When several conditions coincide, the code is chosen by priority: retire, then stall, then wipe complete, then wipe in progress.
- R2: Inputs sampled at one rising edge produce their record on the outputs from that edge until the next one. At most one record exists per cycle.
- R3: An 'S' or 'E' record carries the `pc_i` and `insn_i` values sampled in its cycle.
- R4: A 'U' or 'V' record carries zero in `rec_pc_o` and `rec_insn_o`, whatever the buses hold.
- R5: In a cycle with no condition sampled, `rec_valid_o` is low and every other output is zero.
- R6: `rec_cond_o` shows every condition sampled: bit 0 stall, bit 1 retire, bit 2 wipe in progress, bit 3 wipe complete. If two or more bits are set, `rec_err_o` is high.
- R7: The first stall cycle of an instruction captures its PC. A retire that arrives while such a capture is pending compares `pc_i` against it and sets `rec_err_o` if the two differ. A match, or a retire with no stall before it, raises no error. A retire always clears the capture.
- R8: A 64-bit cycle counter is cleared by synchronous reset and increments on every non-reset edge. `rec_cycle_o` holds the counter value at the edge where the inputs were sampled, which equals the number of non-reset edges before that edge.
- R9: Synchronous active-low reset clears every output and drops any pending stall capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Instruction stalled this cycle |
| retire_i | input | 1 | Instruction retired this cycle |
| wipe_busy_i | input | 1 | Secure wipe in progress this cycle |
| wipe_done_i | input | 1 | Secure wipe finished this cycle |
| pc_i | input | 32 | Program counter of the current instruction |
| insn_i | input | 32 | Raw instruction word |
| rec_valid_o | output | 1 | Record present this cycle |
| rec_code_o | output | 8 | ASCII type character |
| rec_err_o | output | 1 | Conflicting inputs seen |
| rec_cond_o | output | 4 | Mask of the conditions sampled |
| rec_pc_o | output | 32 | PC payload, zero for wipe records |
| rec_insn_o | output | 32 | Instruction payload, zero for wipe records |
| rec_cycle_o | output | 64 | Cycle number of the record |

## Verification
The assertions assume that the four strobes and the buses are free of X after reset, and that the PC bus is stable during any cycle in which a strobe is sampled. They also assume that the counter never wraps during a run. The stimulus changes inputs only on falling edges and holds them for one full cycle. It covers clean stall-then-retire and wipe-then-done sequences, as well as deliberately conflicting combinations and a PC mismatch, so that the error path fires. Runs stay far shorter than the counter's wrap period.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned NCOND  = 4;
  localparam int unsigned CODE_W = 8;

  // condition bit positions in the mask
  localparam int unsigned B_STALL  = 0;
  localparam int unsigned B_RETIRE = 1;
  localparam int unsigned B_WBUSY  = 2;
  localparam int unsigned B_WDONE  = 3;

  localparam logic [CODE_W-1:0] CODE_S = 8'h53;
  localparam logic [CODE_W-1:0] CODE_E = 8'h45;
  localparam logic [CODE_W-1:0] CODE_U = 8'h55;
  localparam logic [CODE_W-1:0] CODE_V = 8'h56;

  // priority: retire > stall > wipe done > wipe busy
  function automatic logic [CODE_W-1:0] code_of(input logic [NCOND-1:0] m);
    if (m[B_RETIRE])      return CODE_E;
    else if (m[B_STALL])  return CODE_S;
    else if (m[B_WDONE])  return CODE_V;
    else if (m[B_WBUSY])  return CODE_U;
    else                  return '0;
  endfunction
endpackage

// File: rtl/trc_cycle_ctr.sv
module trc_cycle_ctr #(
  parameter int unsigned CYC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CYC_W-1:0] count_o
);
  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_CYCLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cnt_q == $past(cnt_q) + 1'b1); // R8
endmodule

// File: rtl/trc_cond_decode.sv
module trc_cond_decode
  import trc_pkg::*;
(
  input  logic              stall_i,
  input  logic              retire_i,
  input  logic              wipe_busy_i,
  input  logic              wipe_done_i,
  output logic [NCOND-1:0]  mask_o,
  output logic              any_o,
  output logic              multi_o,
  output logic              insn_evt_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(NCOND + 1);

  logic [CNT_W-1:0] hits;

  always_comb begin
    mask_o           = '0;
    mask_o[B_STALL]  = stall_i;
    mask_o[B_RETIRE] = retire_i;
    mask_o[B_WBUSY]  = wipe_busy_i;
    mask_o[B_WDONE]  = wipe_done_i;
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < NCOND; i++) hits = hits + CNT_W'(mask_o[i]);
  end

  assign any_o      = |mask_o;
  assign multi_o    = hits > CNT_W'(1);
  assign code_o     = code_of(mask_o);
  assign insn_evt_o = (code_o == CODE_S) || (code_o == CODE_E);

  always_comb begin
    if (any_o) begin
      AST_CODE_LEGAL: assert (code_o == CODE_S || code_o == CODE_E ||
                              code_o == CODE_U || code_o == CODE_V); // R1
    end
  end
endmodule

// File: rtl/trc_stall_track.sv
module trc_stall_track #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            retire_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            mismatch_o
);
  logic            pend_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pc_q   <= '0;
    end else if (retire_i) begin
      pend_q <= 1'b0;
    end else if (stall_i && !pend_q) begin
      pend_q <= 1'b1;
      pc_q   <= pc_i;
    end
  end

  assign mismatch_o = retire_i && pend_q && (pc_i != pc_q);

  AST_PEND_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !retire_i) |=> pend_q); // R7
  AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> !pend_q); // R7
endmodule

// File: rtl/trc_hdr_enc.sv
module trc_hdr_enc
  import trc_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned CYC_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              retire_i,
  input  logic              wipe_busy_i,
  input  logic              wipe_done_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              rec_valid_o,
  output logic [CODE_W-1:0] rec_code_o,
  output logic              rec_err_o,
  output logic [NCOND-1:0]  rec_cond_o,
  output logic [PC_W-1:0]   rec_pc_o,
  output logic [INSN_W-1:0] rec_insn_o,
  output logic [CYC_W-1:0]  rec_cycle_o
);
  logic [CYC_W-1:0]  cyc;
  logic [NCOND-1:0]  mask;
  logic              any, multi, insn_evt, mismatch;
  logic [CODE_W-1:0] code;

  trc_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_o (cyc)
  );

  trc_cond_decode u_dec (
    .stall_i     (stall_i),
    .retire_i    (retire_i),
    .wipe_busy_i (wipe_busy_i),
    .wipe_done_i (wipe_done_i),
    .mask_o      (mask),
    .any_o       (any),
    .multi_o     (multi),
    .insn_evt_o  (insn_evt),
    .code_o      (code)
  );

  trc_stall_track #(.PC_W(PC_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .retire_i   (retire_i),
    .pc_i       (pc_i),
    .mismatch_o (mismatch)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !any) begin
      rec_valid_o <= 1'b0;
      rec_code_o  <= '0;
      rec_err_o   <= 1'b0;
      rec_cond_o  <= '0;
      rec_pc_o    <= '0;
      rec_insn_o  <= '0;
      rec_cycle_o <= '0;
    end else begin
      rec_valid_o <= 1'b1;
      rec_code_o  <= code;
      rec_err_o   <= multi || mismatch;
      rec_cond_o  <= mask;
      rec_pc_o    <= insn_evt ? pc_i   : '0;
      rec_insn_o  <= insn_evt ? insn_i : '0;
      rec_cycle_o <= cyc;
    end
  end

  AST_REC_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i || retire_i || wipe_busy_i || wipe_done_i) |=> rec_valid_o); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> (rec_code_o == '0 && !rec_err_o && rec_cond_o == '0 &&
                      rec_pc_o == '0 && rec_insn_o == '0 && rec_cycle_o == '0)); // R5
  AST_WIPE_NO_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && (rec_code_o == CODE_U || rec_code_o == CODE_V))
      |-> (rec_pc_o == '0 && rec_insn_o == '0)); // R4
  AST_MULTI_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(rec_cond_o) > 1) |-> rec_err_o); // R6
endmodule

// File: tb/test_trc_hdr_enc.sv
`timescale 1ns/1ps
module test_trc_hdr_enc;
  typedef struct packed {
    logic [3:0]  cond;   // [0] stall [1] retire [2] wipe busy [3] wipe done
    logic [31:0] pc;
    logic [31:0] insn;
    logic        ev;
    logic [7:0]  ecode;
    logic        eerr;
    logic [3:0]  emask;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'h00, 1'b0, 4'b0000}, // R5 idle
    '{4'b0010, 32'h0000_0100, 32'hAAAA_0001, 1'b1, 8'h45, 1'b0, 4'b0010}, // R3 plain retire
    '{4'b0001, 32'h0000_0104, 32'hAAAA_0002, 1'b1, 8'h53, 1'b0, 4'b0001}, // R3 stall
    '{4'b0001, 32'h0000_0104, 32'hAAAA_0002, 1'b1, 8'h53, 1'b0, 4'b0001}, // R3 stall again
    '{4'b0010, 32'h0000_0104, 32'hAAAA_0002, 1'b1, 8'h45, 1'b0, 4'b0010}, // R7 match
    '{4'b0001, 32'h0000_0108, 32'hAAAA_0003, 1'b1, 8'h53, 1'b0, 4'b0001}, // R3
    '{4'b0010, 32'h0000_010C, 32'hAAAA_0004, 1'b1, 8'h45, 1'b1, 4'b0010}, // R7 mismatch
    '{4'b0100, 32'h0000_0055, 32'h1234_5678, 1'b1, 8'h55, 1'b0, 4'b0100}, // R4 U
    '{4'b0100, 32'h0000_0066, 32'h1234_5679, 1'b1, 8'h55, 1'b0, 4'b0100}, // R4 U
    '{4'b1000, 32'h0000_0077, 32'h1234_567A, 1'b1, 8'h56, 1'b0, 4'b1000}, // R4 V
    '{4'b0011, 32'h0000_0200, 32'hBBBB_0001, 1'b1, 8'h45, 1'b1, 4'b0011}, // R6 R1 prio
    '{4'b1100, 32'h0000_0210, 32'hBBBB_0002, 1'b1, 8'h56, 1'b1, 4'b1100}, // R6 R1 prio
    '{4'b0101, 32'h0000_0300, 32'hBBBB_0003, 1'b1, 8'h53, 1'b1, 4'b0101}, // R6 R1 prio
    '{4'b0010, 32'h0000_0300, 32'hBBBB_0004, 1'b1, 8'h45, 1'b0, 4'b0010}, // R7 match
    '{4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b0, 4'b0000}  // R5 idle
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0, retire = 1'b0, wbusy = 1'b0, wdone = 1'b0;
  logic [31:0] pc = '0, insn = '0;
  logic        rec_valid, rec_err;
  logic [7:0]  rec_code;
  logic [3:0]  rec_cond;
  logic [31:0] rec_pc, rec_insn;
  logic [63:0] rec_cycle;

  int checks = 0;
  int fails  = 0;
  logic [63:0] edges = '0;   // bench model of the cycle number
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= '0;
    else        edges <= edges + 1;
  end

  trc_hdr_enc i_trc_hdr_enc (
    .clk_i(clk), .rst_ni(rst_n),
    .stall_i(stall), .retire_i(retire), .wipe_busy_i(wbusy), .wipe_done_i(wdone),
    .pc_i(pc), .insn_i(insn),
    .rec_valid_o(rec_valid), .rec_code_o(rec_code), .rec_err_o(rec_err),
    .rec_cond_o(rec_cond), .rec_pc_o(rec_pc), .rec_insn_o(rec_insn),
    .rec_cycle_o(rec_cycle)
  );

  task automatic check(input string req, input logic ev, input logic [7:0] ec,
                       input logic ee, input logic [3:0] em, input logic [31:0] ep,
                       input logic [31:0] ei, input logic [63:0] ecyc);
    checks++;
    if (rec_valid !== ev || rec_code !== ec || rec_err !== ee || rec_cond !== em ||
        rec_pc !== ep || rec_insn !== ei || rec_cycle !== ecyc) begin
      fails++;
      $display("FAIL %s: got v=%b c=%h e=%b m=%b pc=%h in=%h cyc=%0d exp v=%b c=%h e=%b m=%b pc=%h in=%h cyc=%0d",
               req, rec_valid, rec_code, rec_err, rec_cond, rec_pc, rec_insn, rec_cycle,
               ev, ec, ee, em, ep, ei, ecyc);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input string req, input logic [3:0] c, input logic [31:0] p,
                       input logic [31:0] n, input logic ev, input logic [7:0] ec,
                       input logic ee, input logic [3:0] em);
    logic [63:0] ecyc;
    logic        pay;
    {wdone, wbusy, retire, stall} = c;
    pc = p;
    insn = n;
    ecyc = ev ? edges : 64'd0;                   // R8
    pay  = ev && (ec == 8'h53 || ec == 8'h45);   // R3 R4
    @(negedge clk);
    check(req, ev, ec, ee, em, pay ? p : 32'd0, pay ? n : 32'd0, ecyc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", 1'b0, 8'h00, 1'b0, 4'b0000, 32'd0, 32'd0, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      apply("R1-table", VEC[i].cond, VEC[i].pc, VEC[i].insn,
            VEC[i].ev, VEC[i].ecode, VEC[i].eerr, VEC[i].emask);

    // directed: gap of idle cycles then a record checks counter keeps running (R8)
    repeat (5) @(negedge clk);
    apply("R8 cycle after gap", 4'b0010, 32'h0000_0404, 32'hCCCC_0001, 1'b1, 8'h45, 1'b0, 4'b0010);

    // directed: reset drops a pending stall capture (R9, R7)
    apply("R3 stall before reset", 4'b0001, 32'h0000_0400, 32'hCCCC_0002, 1'b1, 8'h53, 1'b0, 4'b0001);
    {wdone, wbusy, retire, stall} = 4'b0001;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 outputs cleared by reset", 1'b0, 8'h00, 1'b0, 4'b0000, 32'd0, 32'd0, 64'd0);
    rst_n = 1'b1;
    apply("R9 capture dropped, no error", 4'b0010, 32'h0000_0500, 32'hCCCC_0003, 1'b1, 8'h45, 1'b0, 4'b0010);

    // directed: wipe done with all buses busy, then idle again (R4 R5)
    apply("R4 V zero payload", 4'b1000, 32'hDEAD_BEEF, 32'hFEED_FACE, 1'b1, 8'h56, 1'b0, 4'b1000);
    apply("R5 idle after wipe", 4'b0000, 32'hDEAD_BEEF, 32'hFEED_FACE, 1'b0, 8'h00, 1'b0, 4'b0000);

    // directed: all four at once (R6 R1 R2)
    apply("R6 all conditions", 4'b1111, 32'h0000_0600, 32'hCCCC_0004, 1'b1, 8'h45, 1'b1, 4'b1111);
    apply("R2 single record after burst", 4'b0000, 32'h0, 32'h0, 1'b0, 8'h00, 1'b0, 4'b0000);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule